// File: doc/BRIEF.md
# Three-Wire Serial Control Register Loader

This block receives programming words for a frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load-enable line. All three pins are synchronized into the system clock domain, and their edges are detected there. Each rising edge of the serial clock shifts the current data bit into a 24-bit input register, most significant bit first. A rising edge on load-enable copies the register into one of four destination latches. The two bits shifted in last, DB1 and DB0, select the destination.

The destinations are a reference-divider latch, a dual-counter latch that holds the A and B values, a function latch and an initialization latch. Each latch keeps bits DB23..DB2 of the word it received. The block also decodes the 14-bit reference divide value and the A and B counts, and drives them out in parallel. A one-cycle update strobe marks each latch that was written, so that downstream counters know when to pick up new values. A word that is shorter or longer than 24 clocks is still transferred, and a length-error flag reports it.

Top module: `serial_prog_loader`

## Requirements
- R1: After reset, all four latches, the decoded fields, the update strobes and the length-error flag are zero.
- R2: Bits are taken only on rising edges of `ser_clk`, entering at the low end of the input register. After 24 rising edges, the first bit sent is DB23 and the last bit sent is DB0.
- R3: Selector `{DB1,DB0}` = 2'b00 writes `ref_word` with DB23..DB2 (DB2 at bit 0). `ref_div` then equals DB15..DB2.
- R4: Selector 2'b01 writes `div_word`. `a_count` then equals DB7..DB2 and `b_count` equals DB20..DB8.
- R5: Selector 2'b10 writes `func_word` with DB23..DB2.
- R6: Selector 2'b11 writes DB23..DB2 into both `init_word` and `func_word`.
- R7: A load leaves unchanged every latch that its selector does not address.
- R8: No latch changes without a rising edge of `ser_le`. Holding `ser_le` high produces exactly one transfer.
- R9: At each load, `len_err` becomes 1 if the number of `ser_clk` rising edges since the previous load differs from 24, and 0 otherwise. The flag holds until the next load. The transfer happens either way, using the last 24 bits shifted in.
- R10: `upd_stb` pulses for exactly one cycle on each load. The bits are: bit 0 for the reference latch, bit 1 for the counter latch, bit 2 for the function latch and bit 3 for the initialization latch. An initialization write raises bits 3 and 2 together.
- R11: The latches, the decoded fields, `len_err` and the strobe all change together, at the fourth rising `clk` edge after `ser_le` rises at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load-enable strobe |
| ref_word | output | 22 | Reference latch, DB23..DB2 |
| div_word | output | 22 | A/B counter latch, DB23..DB2 |
| func_word | output | 22 | Function latch, DB23..DB2 |
| init_word | output | 22 | Initialization latch, DB23..DB2 |
| ref_div | output | 14 | Decoded reference divide value |
| a_count | output | 6 | Decoded A count |
| b_count | output | 13 | Decoded B count |
| upd_stb | output | 4 | One-cycle per-latch update strobes |
| len_err | output | 1 | Last word had a length other than 24 |

## Verification
A pin edge reaches the input register on the third rising `clk` edge after it occurs: two synchronizer stages plus the edge register. A load lands in the latches one edge later, on the fourth. The bench therefore changes the pins only just after a falling `clk` edge and counts four rising edges after raising `ser_le`. At the falling edge that follows, it checks the strobe, every latch, the decoded fields and the length flag. One falling edge later, it checks that the strobe has returned to zero. Data is held steady for three cycles on each side of every serial clock edge, so the synchronized data bit is settled when the shift happens.

// File: rtl/spl_pkg.sv
package spl_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_REF  = 2'b00,
    SEL_DIV  = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_INIT = 2'b11
  } dest_sel_e;

  localparam int R_W = 14;
  localparam int A_W = 6;
  localparam int B_W = 13;

  // Payload is DB23..DB2, so payload bit i is DB(i+2).
  function automatic logic [R_W-1:0] ref_field(input logic [21:0] pay);
    return pay[R_W-1:0];                 // DB15..DB2
  endfunction

  function automatic logic [A_W-1:0] a_field(input logic [21:0] pay);
    return pay[A_W-1:0];                 // DB7..DB2
  endfunction

  function automatic logic [B_W-1:0] b_field(input logic [21:0] pay);
    return pay[A_W+B_W-1:A_W];           // DB20..DB8
  endfunction

  // One-hot strobe pattern for a selector; init also refreshes function.
  function automatic logic [3:0] strobe_of(input dest_sel_e s);
    case (s)
      SEL_REF:  return 4'b0001;
      SEL_DIV:  return 4'b0010;
      SEL_FUNC: return 4'b0100;
      default:  return 4'b1100;
    endcase
  endfunction

endpackage

// File: rtl/spl_pin_sync.sv
module spl_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], pin[g]};
        prev  <= chain[STAGES-1];
      end
    end

    assign lvl[g]  = chain[STAGES-1];
    assign rise[g] = chain[STAGES-1] & ~prev;

    // R8
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> !rise[g]);
  end

endmodule

// File: rtl/spl_shifter.sv
module spl_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              bit_val,
  input  logic              le_rise,
  output logic              load_q,
  output logic [WORD_W-1:0] word_q,
  output logic              len_bad_q
);

  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              shift_ev;

  // A load-enable edge takes priority over a coincident clock edge.
  assign shift_ev = bit_rise & ~le_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      cnt       <= '0;
      load_q    <= 1'b0;
      word_q    <= '0;
      len_bad_q <= 1'b0;
    end else begin
      load_q <= le_rise;
      if (le_rise) begin
        word_q    <= sr;
        len_bad_q <= (cnt != CNT_W'(WORD_W));
        cnt       <= '0;
      end else if (shift_ev) begin
        sr <= {sr[WORD_W-2:0], bit_val};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  shift_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr != $past(sr)) |-> $past(bit_rise));

  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(le_rise) |-> (cnt == '0));

endmodule

// File: rtl/spl_latch_bank.sv
module spl_latch_bank
  import spl_pkg::*;
#(
  parameter int WORD_W = 24,
  localparam int PAY_W = WORD_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              len_bad,
  output logic [PAY_W-1:0]  ref_q,
  output logic [PAY_W-1:0]  div_q,
  output logic [PAY_W-1:0]  func_q,
  output logic [PAY_W-1:0]  init_q,
  output logic [3:0]        upd_q,
  output logic              len_err_q
);

  dest_sel_e         sel;
  logic [PAY_W-1:0]  pay;
  logic [3:0]        wr_en;

  assign sel   = dest_sel_e'(word[SEL_W-1:0]);
  assign pay   = word[WORD_W-1:SEL_W];
  assign wr_en = load ? strobe_of(sel) : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q     <= '0;
      div_q     <= '0;
      func_q    <= '0;
      init_q    <= '0;
      upd_q     <= '0;
      len_err_q <= 1'b0;
    end else begin
      upd_q <= wr_en;
      if (wr_en[0]) ref_q  <= pay;
      if (wr_en[1]) div_q  <= pay;
      if (wr_en[2]) func_q <= pay;
      if (wr_en[3]) init_q <= pay;
      if (load)     len_err_q <= len_bad;
    end
  end

  // R7
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q != $past(ref_q)) |-> upd_q[0]);
  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != $past(div_q)) |-> upd_q[1]);
  // R7
  func_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func_q != $past(func_q)) |-> upd_q[2]);
  // R7
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q != $past(init_q)) |-> upd_q[3]);
  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q != 4'b0000) |=> (upd_q == 4'b0000));
  // R6
  init_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q[3] |-> upd_q[2]);
  // R10
  strobe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(upd_q) <= 1) || (upd_q == 4'b1100));
  // R9
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_err_q != $past(len_err_q)) |-> (upd_q != 4'b0000));

endmodule

// File: rtl/serial_prog_loader.sv
module serial_prog_loader
  import spl_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2,
  localparam int PAY_W      = WORD_W - SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_le,
  output logic [PAY_W-1:0] ref_word,
  output logic [PAY_W-1:0] div_word,
  output logic [PAY_W-1:0] func_word,
  output logic [PAY_W-1:0] init_word,
  output logic [R_W-1:0]   ref_div,
  output logic [A_W-1:0]   a_count,
  output logic [B_W-1:0]   b_count,
  output logic [3:0]       upd_stb,
  output logic             len_err
);

  localparam int LINES = 3;
  localparam int L_CLK = 0;
  localparam int L_DAT = 1;
  localparam int L_LE  = 2;

  logic [LINES-1:0]  pins, lvl, rise;
  logic              sclk_rise, data_lvl, le_rise;
  logic              load_ev;
  logic [WORD_W-1:0] load_word;
  logic              load_len_bad;
  logic              unused_sync;

  assign pins        = {ser_le, ser_data, ser_clk};
  assign sclk_rise   = rise[L_CLK];
  assign data_lvl    = lvl[L_DAT];
  assign le_rise     = rise[L_LE];
  assign unused_sync = ^{lvl[L_CLK], lvl[L_LE], rise[L_DAT]};

  spl_pin_sync #(.N(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pins),
    .lvl  (lvl),
    .rise (rise)
  );

  spl_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_rise (sclk_rise),
    .bit_val  (data_lvl),
    .le_rise  (le_rise),
    .load_q   (load_ev),
    .word_q   (load_word),
    .len_bad_q(load_len_bad)
  );

  spl_latch_bank #(.WORD_W(WORD_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ev),
    .word     (load_word),
    .len_bad  (load_len_bad),
    .ref_q    (ref_word),
    .div_q    (div_word),
    .func_q   (func_word),
    .init_q   (init_word),
    .upd_q    (upd_stb),
    .len_err_q(len_err)
  );

  assign ref_div = ref_field(ref_word);
  assign a_count = a_field(div_word);
  assign b_count = b_field(div_word);

  // R11
  load_to_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (upd_stb != 4'b0000));

endmodule

// File: tb/serial_prog_loader_tb.sv
module serial_prog_loader_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [21:0] ref_word, div_word, func_word, init_word;
  logic [13:0] ref_div;
  logic [5:0]  a_count;
  logic [12:0] b_count;
  logic [3:0]  upd_stb;
  logic        len_err;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  bit done = 0;

  // Bench-side model
  logic [23:0] m_sr = '0;
  int          m_cnt = 0;
  logic [21:0] e_ref = '0, e_div = '0, e_func = '0, e_init = '0;

  always #10 clk = ~clk;

  serial_prog_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .ref_word(ref_word), .div_word(div_word),
    .func_word(func_word), .init_word(init_word), .ref_div(ref_div),
    .a_count(a_count), .b_count(b_count), .upd_stb(upd_stb), .len_err(len_err)
  );

  always @(posedge clk) if (upd_stb != 4'b0000) strobes++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); ser_data = w[i];
      wait_neg(3); ser_clk = 1'b1;
      wait_neg(3); ser_clk = 1'b0;
      wait_neg(3);
      m_sr = {m_sr[22:0], w[i]};
      m_cnt++;
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R7 ref"},  ref_word,  e_ref);
    chk({tag, " R7 div"},  div_word,  e_div);
    chk({tag, " R7 func"}, func_word, e_func);
    chk({tag, " R7 init"}, init_word, e_init);
    chk({tag, " R3 ref_div"}, ref_div, e_ref[13:0]);
    chk({tag, " R4 a_count"}, a_count, e_div[5:0]);
    chk({tag, " R4 b_count"}, b_count, e_div[18:6]);
  endtask

  task automatic load_and_check();
    logic [21:0] pay;
    logic [1:0]  sel;
    logic [3:0]  e_upd;
    logic        e_len;
    int          s0;
    string       tag;
    pay   = m_sr[23:2];
    sel   = m_sr[1:0];
    e_len = (m_cnt != 24);
    m_cnt = 0;
    case (sel)
      2'b00: begin e_ref = pay; e_upd = 4'b0001; tag = "R3"; end
      2'b01: begin e_div = pay; e_upd = 4'b0010; tag = "R4"; end
      2'b10: begin e_func = pay; e_upd = 4'b0100; tag = "R5"; end
      default: begin e_init = pay; e_func = pay; e_upd = 4'b1100; tag = "R6"; end
    endcase
    @(negedge clk);
    s0 = strobes;
    ser_le = 1'b1;
    for (int i = 0; i < 4; i++) @(posedge clk);
    @(negedge clk);
    chk({tag, " R10 R11 strobe"}, upd_stb, e_upd);
    chk({tag, " R9 len_err"}, len_err, e_len);
    check_all(tag);
    @(negedge clk);
    chk("R10 strobe one cycle", upd_stb, 4'b0000);
    wait_neg(10);
    chk("R8 single transfer while LE high", strobes - s0, 1);
    ser_le = 1'b0;
    wait_neg(4);
  endtask

  initial begin
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(2);
    chk("R1 strobe", upd_stb, 4'b0000);
    chk("R1 len_err", len_err, 1'b0);
    check_all("R1");

    // R2..R6, R10, R11: every selector with several payloads
    for (int k = 0; k < 5; k++) begin
      for (int s = 0; s < 4; s++) begin
        logic [21:0] p;
        p = 22'(k * 32'h2D4B7 + s * 32'h15A3C) ^ 22'h2A5A5A;
        send_bits({8'h00, p, 2'(s)}, 24);
        load_and_check();
      end
    end
    // R2 pattern extremes on the counter latch
    send_bits({8'h00, 22'h3FFFFF, 2'b01}, 24); load_and_check();
    send_bits({8'h00, 22'h000000, 2'b01}, 24); load_and_check();

    // R8: full word, no LE: nothing changes
    begin
      int s0;
      s0 = strobes;
      send_bits(32'h00ABCDE2, 24);
      wait_neg(6);
      chk("R8 no strobe without LE", strobes - s0, 0);
      check_all("R8");
    end
    load_and_check();   // 24 bits pending, length correct

    // R9: short (20) and long (27) words still transfer
    send_bits(32'h000F0F0, 20); load_and_check();
    send_bits(32'h05A5A5A6, 27); load_and_check();
    send_bits(32'h00C0FFEE, 24); load_and_check();   // R9 clears again

    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule